// File: doc/BRIEF.md
# Sectioned I2C Register Access Controller

This block is the byte-level back end of an I2C target that fronts the register bank of a real-time clock. A bit-level engine, which is not part of the block, detects start and stop conditions, shifts bytes in and out, and reports each event to this block through single-cycle strobes. The block checks the device address and holds the internal register pointer. It stores the status, control, daylight-saving and alarm registers, and it returns read data. Writes aimed at the eight timekeeping bytes are passed on as a strobe, with an index and a data byte, to the timekeeping logic. That logic is outside the block.

The register space is split into sections. A burst read or write moves the pointer forward but never out of the section it started in: when the pointer steps past the section's last address, it returns to the section's first address. Writes to the timekeeping bytes pass only while a write-enable bit in the first control register is set. Whenever a read starts in the timekeeping or alarm section, the block copies the live time into a buffer. Timekeeping bytes are served from that buffer, so a clock tick during the burst cannot tear the value being read.

Top module: `sectioned_reg_access`

## Requirements
- R1: After a start, the first byte is the device byte. Bits 7:1 equal to 1101111 are acknowledged and bit 0 selects read (1) or write (0). Any other device byte is not acknowledged, and every byte up to the next start is then ignored with ack_o low.
- R2: In a write transfer, the byte after the device byte is the register address. Values 00h to 47h are acknowledged and loaded into the pointer. A larger value is not acknowledged, leaves the pointer unchanged and ends the transfer.
- R3: The sections are 00h-07h (timekeeping), 08h (status), {0Ch, 13h} (control), 15h-1Ch (daylight saving) and 1Dh-28h (alarm). Every other address forms a section of its own. Each data byte written or read moves the pointer to the next address of its section. From the section's last address the pointer goes to its first address, and in the control section 0Ch and 13h alternate.
- R4: A data byte written to a stored register keeps only the bits of that register's mask: 08h B1h, 0Ch F3h, 13h C0h, every other stored register FFh. Bits outside the mask read as 0. Addresses outside all sections ignore writes and read as 00h. Every data byte of a write transfer is acknowledged.
- R5: A data byte written to address 00h-07h raises time_we_o for one cycle, with time_idx_o set to the address and time_wdata_o set to the byte. This happens only when bit 6 of register 0Ch is 1. Otherwise the byte has no effect.
- R6: An acknowledged read device byte with the pointer in 00h-07h or 1Dh-28h copies time_in (byte n is bits 8n+7:8n) into a buffer. Reads of 00h-07h return the buffered bytes, whatever time_in does afterwards.
- R7: Each byte read leaves the pointer on the next address of the section. A later read transfer that sends no register address continues from there.
- R8: After a synchronous reset with rst_n low, the defaults are 08h=01h, 0Ch=01h, 13h=00h, 15h-1Ch = 04h,00h,01h,02h,10h,00h,01h,02h, and 1Dh-22h and 23h-28h each = 00h,00h,00h,01h,01h,00h. The pointer is 00h, and ack_o, tx_byte_o and time_we_o are 0.
- R9: ack_o takes its new value the cycle after rx_valid_i and holds it until the next received byte or start. tx_byte_o takes the byte at the pointer the cycle after tx_req_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start or repeated start detected |
| stop_i | input | 1 | Stop detected |
| rx_valid_i | input | 1 | A received byte is on rx_byte_i |
| rx_byte_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Engine wants the next byte to send |
| tx_byte_o | output | 8 | Byte to send |
| ack_o | output | 1 | Acknowledge decision for the last received byte |
| time_in | input | 64 | Live timekeeping bytes, byte n at bits 8n+7:8n |
| time_we_o | output | 1 | Timekeeping byte write strobe |
| time_idx_o | output | 3 | Timekeeping byte index |
| time_wdata_o | output | 8 | Timekeeping byte data |

## Verification
The bench writes bursts that run off the end of the daylight-saving and alarm sections and across the split control pair. A pointer that fails to wrap correctly writes into a neighbouring section, or into empty space, and the next readback shows it. Timekeeping writes are tried with the enable bit cleared and with it set. A wrong gate shows up at time_we_o, either as a stray strobe or as a missing one. During reads the live time is changed after the device byte. A design that reads the live time, or that copies it at the wrong moment, then returns the new value instead of the copied one. Out-of-range register addresses, foreign device bytes and current-address reads check that the pointer survives a rejected transfer and carries over between transfers.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int DATA_W = 8;
  localparam int NSLOT  = 23;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef logic [7:0] addr_t;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_WORD, ST_WDATA, ST_RDATA} xfer_st_e;

  localparam addr_t A_TK_HI  = 8'h07;
  localparam addr_t A_STAT   = 8'h08;
  localparam addr_t A_CTL0   = 8'h0C;
  localparam addr_t A_CTL1   = 8'h13;
  localparam addr_t A_DST_LO = 8'h15;
  localparam addr_t A_DST_HI = 8'h1C;
  localparam addr_t A_ALM_LO = 8'h1D;
  localparam addr_t A_ALM_HI = 8'h28;

  function automatic logic in_tk(addr_t a);
    return a <= A_TK_HI;
  endfunction

  function automatic logic in_dst(addr_t a);
    return (a >= A_DST_LO) && (a <= A_DST_HI);
  endfunction

  function automatic logic in_alm(addr_t a);
    return (a >= A_ALM_LO) && (a <= A_ALM_HI);
  endfunction

  function automatic addr_t sec_lo(addr_t a);
    if (in_tk(a))  return 8'h00;
    if (in_dst(a)) return A_DST_LO;
    if (in_alm(a)) return A_ALM_LO;
    return a;
  endfunction

  function automatic addr_t sec_hi(addr_t a);
    if (in_tk(a))  return A_TK_HI;
    if (in_dst(a)) return A_DST_HI;
    if (in_alm(a)) return A_ALM_HI;
    return a;
  endfunction

  // section identity: the two control registers share one tag
  function automatic addr_t sec_tag(addr_t a);
    if (a == A_CTL1) return A_CTL0;
    return sec_lo(a);
  endfunction

  function automatic addr_t next_addr(addr_t a);
    if (a == A_CTL0) return A_CTL1;
    if (a == A_CTL1) return A_CTL0;
    if (a == sec_hi(a)) return sec_lo(a);
    return a + 8'd1;
  endfunction

  function automatic logic is_stored(addr_t a);
    return (a == A_STAT) || (a == A_CTL0) || (a == A_CTL1) || in_dst(a) || in_alm(a);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(addr_t a);
    if (a == A_STAT) return SLOT_W'(0);
    if (a == A_CTL0) return SLOT_W'(1);
    if (a == A_CTL1) return SLOT_W'(2);
    if (in_dst(a))   return SLOT_W'(a - A_DST_LO + 8'd3);
    if (in_alm(a))   return SLOT_W'(a - A_ALM_LO + 8'd11);
    return SLOT_W'(0);
  endfunction

  function automatic addr_t addr_of_slot(int s);
    if (s == 0) return A_STAT;
    if (s == 1) return A_CTL0;
    if (s == 2) return A_CTL1;
    if (s < 11) return A_DST_LO + 8'(s - 3);
    return A_ALM_LO + 8'(s - 11);
  endfunction

  function automatic logic [7:0] wmask(addr_t a);
    case (a)
      A_STAT:  return 8'hB1;
      A_CTL0:  return 8'hF3;
      A_CTL1:  return 8'hC0;
      default: return is_stored(a) ? 8'hFF : 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] dflt(addr_t a);
    addr_t off;
    if (a == A_STAT || a == A_CTL0) return 8'h01;
    if (in_dst(a)) begin
      case (a - A_DST_LO)
        8'd0:    return 8'h04;
        8'd3:    return 8'h02;
        8'd4:    return 8'h10;
        8'd7:    return 8'h02;
        8'd2:    return 8'h01;
        8'd6:    return 8'h01;
        default: return 8'h00;
      endcase
    end
    if (in_alm(a)) begin
      off = (a >= A_ALM_LO + 8'd6) ? a - A_ALM_LO - 8'd6 : a - A_ALM_LO;
      return (off == 8'd3 || off == 8'd4) ? 8'h01 : 8'h00;
    end
    return 8'h00;
  endfunction
endpackage

// File: rtl/sra_snapshot.sv
module sra_snapshot #(
  parameter int NBYTE = 8,
  localparam int IDX_W = $clog2(NBYTE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_i,
  input  logic [NBYTE*8-1:0]   time_i,
  input  logic [IDX_W-1:0]     sel_i,
  output logic [7:0]           byte_o
);
  logic [NBYTE*8-1:0] held_q;
  logic [7:0]         lane [NBYTE];

  always_ff @(posedge clk) begin
    if (!rst_n)     held_q <= '0;
    else if (cap_i) held_q <= time_i;
  end

  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    assign lane[g] = held_q[g*8 +: 8];
  end

  assign byte_o = lane[sel_i];

  AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(held_q)); // R6
endmodule

// File: rtl/sra_reg_bank.sv
module sra_reg_bank
  import sra_pkg::*;
#(
  parameter int WE_BIT = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_i,
  input  addr_t waddr_i,
  input  logic [7:0] wdata_i,
  input  addr_t raddr_i,
  output logic [7:0] rdata_o,
  output logic  wrtc_o
);
  logic [7:0] mem [NSLOT];
  logic       hit_w;

  assign hit_w = we_i && is_stored(waddr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) mem[s] <= dflt(addr_of_slot(s));
    end else if (hit_w) begin
      mem[slot_of(waddr_i)] <= wdata_i & wmask(waddr_i);
    end
  end

  assign rdata_o = is_stored(raddr_i) ? mem[slot_of(raddr_i)] : 8'h00;
  assign wrtc_o  = mem[slot_of(A_CTL0)][WE_BIT];

  AST_MASKED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~wmask(raddr_i)) == 8'h00); // R4
endmodule

// File: rtl/sra_xfer_fsm.sv
module sra_xfer_fsm
  import sra_pkg::*;
#(
  parameter logic [6:0] DEV_ID    = 7'h6F,
  parameter addr_t      ADDR_LAST = 8'h47,
  parameter int         TK_BYTES  = 8,
  localparam int        IDX_W     = $clog2(TK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             tx_req_i,
  input  logic             wrtc_i,
  output logic             ack_o,
  output addr_t            ptr_o,
  output logic             wr_evt_o,
  output logic             rd_evt_o,
  output logic             snap_evt_o,
  output logic             time_we_o,
  output logic [IDX_W-1:0] time_idx_o,
  output logic [7:0]       time_wdata_o
);
  xfer_st_e st_q;
  addr_t    ptr_q;
  logic     quiet_w, byte_w, dev_hit_w, adv_evt_w;

  assign quiet_w    = !start_i && !stop_i;
  assign byte_w     = quiet_w && rx_valid_i;
  assign dev_hit_w  = rx_byte_i[7:1] == DEV_ID;
  assign wr_evt_o   = byte_w && (st_q == ST_WDATA);
  assign rd_evt_o   = quiet_w && !rx_valid_i && tx_req_i && (st_q == ST_RDATA);
  assign snap_evt_o = byte_w && (st_q == ST_DEV) && dev_hit_w && rx_byte_i[0]
                      && (in_tk(ptr_q) || in_alm(ptr_q));
  assign adv_evt_w  = wr_evt_o || rd_evt_o;
  assign ptr_o      = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      ptr_q        <= '0;
      ack_o        <= 1'b0;
      time_we_o    <= 1'b0;
      time_idx_o   <= '0;
      time_wdata_o <= '0;
    end else begin
      time_we_o <= 1'b0;
      if (start_i) begin
        st_q  <= ST_DEV;
        ack_o <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
      end else if (rx_valid_i) begin
        case (st_q)
          ST_DEV: begin
            ack_o <= dev_hit_w;
            if (!dev_hit_w)        st_q <= ST_IDLE;
            else if (rx_byte_i[0]) st_q <= ST_RDATA;
            else                   st_q <= ST_WORD;
          end
          ST_WORD: begin
            if (rx_byte_i <= ADDR_LAST) begin
              ack_o <= 1'b1;
              ptr_q <= rx_byte_i;
              st_q  <= ST_WDATA;
            end else begin
              ack_o <= 1'b0;
              st_q  <= ST_IDLE;
            end
          end
          ST_WDATA: begin
            ack_o <= 1'b1;
            ptr_q <= next_addr(ptr_q);
            if (in_tk(ptr_q) && wrtc_i) begin
              time_we_o    <= 1'b1;
              time_idx_o   <= ptr_q[IDX_W-1:0];
              time_wdata_o <= rx_byte_i;
            end
          end
          default: ack_o <= 1'b0;
        endcase
      end else if (rd_evt_o) begin
        ptr_q <= next_addr(ptr_q);
      end
    end
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= ADDR_LAST); // R2
  AST_ADV_STAYS_IN_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt_w |=> sec_tag(ptr_q) == sec_tag($past(ptr_q))); // R3
  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_w && st_q == ST_DEV && !dev_hit_w) |=> !ack_o); // R1
  AST_DATA_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt_o |=> ack_o); // R4
endmodule

// File: rtl/sectioned_reg_access.sv
module sectioned_reg_access
  import sra_pkg::*;
#(
  parameter logic [6:0] DEV_ID    = 7'h6F,
  parameter logic [7:0] ADDR_LAST = 8'h47,
  parameter int         WE_BIT    = 6,
  parameter int         TK_BYTES  = 8,
  localparam int        IDX_W     = $clog2(TK_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  rx_valid_i,
  input  logic [7:0]            rx_byte_i,
  input  logic                  tx_req_i,
  output logic [7:0]            tx_byte_o,
  output logic                  ack_o,
  input  logic [TK_BYTES*8-1:0] time_in,
  output logic                  time_we_o,
  output logic [IDX_W-1:0]      time_idx_o,
  output logic [7:0]            time_wdata_o
);
  addr_t      ptr_w;
  logic       wr_evt_w, rd_evt_w, snap_evt_w, wrtc_w;
  logic [7:0] bank_rd_w, snap_rd_w, rd_byte_w;

  sra_xfer_fsm #(.DEV_ID(DEV_ID), .ADDR_LAST(ADDR_LAST), .TK_BYTES(TK_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i),
    .wrtc_i(wrtc_w), .ack_o(ack_o), .ptr_o(ptr_w), .wr_evt_o(wr_evt_w),
    .rd_evt_o(rd_evt_w), .snap_evt_o(snap_evt_w), .time_we_o(time_we_o),
    .time_idx_o(time_idx_o), .time_wdata_o(time_wdata_o)
  );

  sra_reg_bank #(.WE_BIT(WE_BIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(wr_evt_w), .waddr_i(ptr_w),
    .wdata_i(rx_byte_i), .raddr_i(ptr_w), .rdata_o(bank_rd_w), .wrtc_o(wrtc_w)
  );

  sra_snapshot #(.NBYTE(TK_BYTES)) u_snap (
    .clk(clk), .rst_n(rst_n), .cap_i(snap_evt_w), .time_i(time_in),
    .sel_i(ptr_w[IDX_W-1:0]), .byte_o(snap_rd_w)
  );

  assign rd_byte_w = in_tk(ptr_w) ? snap_rd_w : bank_rd_w;

  always_ff @(posedge clk) begin
    if (!rst_n)        tx_byte_o <= 8'h00;
    else if (rd_evt_w) tx_byte_o <= rd_byte_w;
  end

  AST_TIME_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    time_we_o |-> $past(wrtc_w)); // R5
  AST_TX_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt_w |=> $stable(tx_byte_o)); // R9
endmodule

// File: tb/sectioned_reg_access_bench.sv
module sectioned_reg_access_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_i = 0, stop_i = 0, rx_valid_i = 0, tx_req_i = 0;
  logic [7:0]  rx_byte_i = 0;
  logic [63:0] tv = 64'h0;
  logic [7:0]  tx_byte_o;
  logic        ack_o, time_we_o;
  logic [2:0]  time_idx_o;
  logic [7:0]  time_wdata_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_reg [0:71];
  logic [7:0] m_snap [0:7];
  logic [7:0] m_ptr;
  int         m_st;  // 0 idle 1 dev 2 word 3 wdata 4 rdata

  always #10 clk = ~clk;

  sectioned_reg_access u_sectioned_reg_access (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i),
    .tx_byte_o(tx_byte_o), .ack_o(ack_o), .time_in(tv), .time_we_o(time_we_o),
    .time_idx_o(time_idx_o), .time_wdata_o(time_wdata_o)
  );

  function automatic logic [7:0] b_mask(logic [7:0] a);
    if (a == 8'h08) return 8'hB1;
    if (a == 8'h0C) return 8'hF3;
    if (a == 8'h13) return 8'hC0;
    if (a >= 8'h15 && a <= 8'h28) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_default(logic [7:0] a);
    logic [7:0] dst [0:7];
    logic [7:0] alm [0:5];
    dst = '{8'h04, 8'h00, 8'h01, 8'h02, 8'h10, 8'h00, 8'h01, 8'h02};
    alm = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
    if (a == 8'h08 || a == 8'h0C) return 8'h01;
    if (a >= 8'h15 && a <= 8'h1C) return dst[a - 8'h15];
    if (a >= 8'h1D && a <= 8'h28) return alm[(a - 8'h1D) % 6];
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_next(logic [7:0] a);
    if (a <= 8'h07) return (a == 8'h07) ? 8'h00 : a + 1;
    if (a == 8'h0C) return 8'h13;
    if (a == 8'h13) return 8'h0C;
    if (a >= 8'h15 && a <= 8'h1C) return (a == 8'h1C) ? 8'h15 : a + 1;
    if (a >= 8'h1D && a <= 8'h28) return (a == 8'h28) ? 8'h1D : a + 1;
    return a;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    check("R9", "ack cleared by start", ack_o, 0);
    m_st = 1;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
    m_st = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    logic exp_ack, exp_twe;
    logic [2:0] exp_idx;
    string req;
    exp_ack = 0; exp_twe = 0; exp_idx = 0; req = "R1";
    case (m_st)
      1: begin
        req = "R1";
        if (b[7:1] == 7'b1101111) begin
          exp_ack = 1;
          if (b[0]) begin
            m_st = 4;
            if (m_ptr <= 8'h07 || (m_ptr >= 8'h1D && m_ptr <= 8'h28))
              for (int i = 0; i < 8; i++) m_snap[i] = tv[i*8 +: 8];
          end else m_st = 2;
        end else m_st = 0;
      end
      2: begin
        req = "R2";
        if (b <= 8'h47) begin exp_ack = 1; m_ptr = b; m_st = 3; end
        else m_st = 0;
      end
      3: begin
        req = "R4";
        exp_ack = 1;
        if (m_ptr <= 8'h07) begin exp_twe = m_reg[8'h0C][6]; exp_idx = m_ptr[2:0]; end
        else m_reg[m_ptr] = b & b_mask(m_ptr);
        m_ptr = b_next(m_ptr);
      end
      default: req = "R1";
    endcase
    @(negedge clk) begin rx_valid_i = 1; rx_byte_i = b; end
    @(negedge clk) rx_valid_i = 0;
    check(req, "ack", ack_o, exp_ack);
    check("R5", "time write strobe", time_we_o, exp_twe);
    if (exp_twe) begin
      check("R5", "time index", time_idx_o, exp_idx);
      check("R5", "time data", time_wdata_o, b);
    end
  endtask

  task automatic take_byte(input string req);
    logic [7:0] exp;
    exp = (m_ptr <= 8'h07) ? m_snap[m_ptr] : m_reg[m_ptr];
    @(negedge clk) tx_req_i = 1;
    @(negedge clk) tx_req_i = 0;
    check(req, "read byte", tx_byte_o, exp);
    m_ptr = b_next(m_ptr);
  endtask

  task automatic write_burst(input logic [7:0] a, input int n, input logic [7:0] seed);
    do_start(); put_byte(8'hDE); put_byte(a);
    for (int i = 0; i < n; i++) put_byte(seed + 8'(i * 37));
    do_stop();
  endtask

  task automatic set_ptr(input logic [7:0] a);
    do_start(); put_byte(8'hDE); put_byte(a);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 72; a++) m_reg[a] = b_default(8'(a));
    for (int i = 0; i < 8; i++) m_snap[i] = 0;
    m_ptr = 0; m_st = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8", "ack after reset", ack_o, 0);
    check("R8", "tx after reset", tx_byte_o, 0);
    check("R8", "time strobe after reset", time_we_o, 0);

    // R8: every register default, via read bursts through each section
    set_ptr(8'h08); do_start(); put_byte(8'hDF); take_byte("R8"); take_byte("R8"); do_stop();
    set_ptr(8'h0C); do_start(); put_byte(8'hDF); take_byte("R8"); take_byte("R8"); do_stop();
    set_ptr(8'h15); do_start(); put_byte(8'hDF);
    for (int i = 0; i < 8; i++) take_byte("R8");
    do_stop();
    set_ptr(8'h1D); do_start(); put_byte(8'hDF);
    for (int i = 0; i < 12; i++) take_byte("R8");
    do_stop();

    // R1: foreign device byte, following bytes ignored
    do_start(); put_byte(8'hA0); put_byte(8'h08); put_byte(8'h55); do_stop();
    set_ptr(8'h08); do_start(); put_byte(8'hDF); take_byte("R1"); do_stop();

    // R2: out-of-range register address leaves pointer
    set_ptr(8'h16); do_stop();
    do_start(); put_byte(8'hDE); put_byte(8'h48); do_stop();
    do_start(); put_byte(8'hDF); take_byte("R2"); do_stop();

    // R3: wrap at end of daylight section, alarm section, control pair
    write_burst(8'h1C, 3, 8'h11);
    write_burst(8'h28, 2, 8'h5A);
    write_burst(8'h13, 3, 8'hFF);
    set_ptr(8'h1B); do_start(); put_byte(8'hDF);
    for (int i = 0; i < 4; i++) take_byte("R3");
    do_stop();
    set_ptr(8'h13); do_start(); put_byte(8'hDF);
    for (int i = 0; i < 3; i++) take_byte("R3");
    do_stop();

    // R4: undefined address ignores write and reads zero; masks
    write_burst(8'h10, 2, 8'hC3);
    write_burst(8'h08, 1, 8'hFF);
    set_ptr(8'h10); do_start(); put_byte(8'hDF); take_byte("R4"); take_byte("R4"); do_stop();
    set_ptr(8'h08); do_start(); put_byte(8'hDF); take_byte("R4"); do_stop();

    // R5: timekeeping writes blocked, then enabled (0Ch bit 6)
    write_burst(8'h03, 2, 8'h21);
    write_burst(8'h0C, 1, 8'h40);
    write_burst(8'h06, 4, 8'h09);
    write_burst(8'h0C, 1, 8'h00);
    write_burst(8'h00, 1, 8'h33);

    // R6: snapshot frozen while time changes mid-read
    tv = 64'h0706050403020100;
    set_ptr(8'h05); do_start(); put_byte(8'hDF);
    tv = 64'hFFEEDDCCBBAA9988;
    for (int i = 0; i < 5; i++) take_byte("R6");
    do_stop();

    // R7: current-address read continues after previous read
    do_start(); put_byte(8'hDF); take_byte("R7"); take_byte("R7"); do_stop();
    set_ptr(8'h1E); do_start(); put_byte(8'hDF); take_byte("R7"); do_stop();
    do_start(); put_byte(8'hDF); take_byte("R7"); do_stop();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int kind;
      logic [7:0] a;
      int n;
      kind = $urandom_range(0, 3);
      a = 8'($urandom_range(0, 8'h4F));
      n = $urandom_range(1, 6);
      if ($urandom_range(0, 3) == 0) tv = {$urandom, $urandom};
      case (kind)
        0: write_burst(a, n, 8'($urandom));
        1: begin
          set_ptr(a);
          if (m_st == 3) begin
            do_start(); put_byte(8'hDF);
            for (int i = 0; i < n; i++) begin
              if ($urandom_range(0, 1) == 1) tv = {$urandom, $urandom};
              take_byte(m_ptr <= 8'h07 ? "R6" : "R7");
            end
          end
          do_stop();
        end
        2: begin
          do_start(); put_byte(8'hDF);
          for (int i = 0; i < n; i++) take_byte("R7");
          do_stop();
        end
        default: begin
          do_start(); put_byte(8'($urandom) | 8'h01);
          if (m_st == 4) for (int i = 0; i < n; i++) take_byte("R7");
          else put_byte(8'($urandom));
          do_stop();
        end
      endcase
      if (it % 50 == 0) write_burst(8'h0C, 1, $urandom_range(0, 1) ? 8'h40 : 8'h00);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule